// File: doc/BRIEF.md
# Fuse Array Parallel Read Port

This block puts a small one-time-programmable fuse array behind three memory-mapped registers. A control register holds the access mode, a power-on enable, a word-pointer clear and a read strobe. A data port returns one 32-bit slice of the array per read. A pointer register can make the word pointer advance after each data-port read. The array contents come from a parameter and are fixed at reset. They reach the data port only after software has run the bring-up sequence: select parallel mode, enable power, clear the pointer, then drive the strobe high, low for long enough, and high again. On that final rising edge the array is copied into a set of shadow word registers, and software then reads those words one after another.

Register traffic uses a valid/ready request channel and a valid/ready response channel. Each accepted request, read or write, produces exactly one response on the next clock edge. A write response carries zero. While a response is waiting and `resp_ready` is low, the response holds its data and `req_ready` stays low, so back-pressure on the response side stalls the request side.

Registers, by byte offset: control at 0x00, data port at 0x04, pointer at 0x08.

Top module: `otp_par_read_port`

## Requirements
- R1: After reset the control register reads 0x0000_8000 (serial mode, power off, pointer clear and strobe low). The pointer register reads 0 and the data port reads 0.
- R2: The control register keeps bit 15 (serial mode when 1), bit 14 (pointer clear), bit 13 (power on when 1) and bit 3 (strobe). Every other bit reads back as 0.
- R3: A data-port read returns 0 when bit 13 is clear, when bit 15 is set, or when no valid strobe sequence has latched the array since the last power-off.
- R4: The array is latched on a rising edge of the strobe that follows a falling edge, when the strobe stayed low for at least STROBE_MIN_CYC clock cycles and the block was powered and in parallel mode at the rise. A rise with no earlier fall latches nothing.
- R5: A strobe low time shorter than STROBE_MIN_CYC cycles leaves the latched data and its valid state unchanged.
- R6: Word k of the data port holds fuse bits 32k+31 down to 32k. There are ceil(FUSE_BITS/32) words, and bits above FUSE_BITS-1 read as 0.
- R7: While control bit 14 is 1, the word pointer is held at 0. Writing 1 and then 0 leaves it at word 0.
- R8: Bit 8 of the pointer register enables auto-increment. The low bits of the pointer register read back the current word pointer. With auto-increment on, each data-port read moves the pointer up by one and stops at the last word.
- R9: With auto-increment off, data-port reads leave the word pointer unchanged.
- R10: Clearing control bit 13 makes the latched data invalid. A new strobe sequence is needed before data is returned again.
- R11: Each accepted request gives exactly one response on the next edge. While `resp_valid` is high and `resp_ready` is low, the response and its data stay unchanged and `req_ready` stays low.
- R12: A read of any address other than the three offsets returns 0. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_rdata | output | 32 | Read data (0 for writes) |

## Verification
The bench builds the port with FUSE_BITS = 97 and a fuse value whose top word holds only bit 96. That gives four words, so the saturating pointer, the last-word zero padding and the two-bit pointer readback can all be checked. STROBE_MIN_CYC is set to 6. Plain back-to-back register writes then give a strobe low time shorter than the limit, and a short idle gap gives one that meets it, so both the short-pulse and the valid-pulse cases are reached without long waits.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int WORD_W = 32;

  // Register byte offsets
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_DATA = 'h04;
  localparam int OFS_PTR  = 'h08;

  // Control field positions
  localparam int B_SERIAL = 15;
  localparam int B_PCLR   = 14;
  localparam int B_PWR    = 13;
  localparam int B_STRB   = 3;
  // Pointer register field
  localparam int B_AINC   = 8;

  typedef struct packed {
    logic serial;
    logic ptr_clr;
    logic pwr_on;
    logic strobe;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{serial: 1'b1, ptr_clr: 1'b0, pwr_on: 1'b0, strobe: 1'b0};

  function automatic ctrl_t ctrl_unpack(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.serial  = w[B_SERIAL];
    c.ptr_clr = w[B_PCLR];
    c.pwr_on  = w[B_PWR];
    c.strobe  = w[B_STRB];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_pack(input ctrl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_SERIAL] = c.serial;
    w[B_PCLR]   = c.ptr_clr;
    w[B_PWR]    = c.pwr_on;
    w[B_STRB]   = c.strobe;
    return w;
  endfunction
endpackage

// File: rtl/otp_rsp_stage.sv
module otp_rsp_stage
  import otp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  output logic              req_ready,
  output logic              accept,
  input  logic [WORD_W-1:0] rd_word,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [WORD_W-1:0] resp_rdata
);
  logic              vld_q;
  logic [WORD_W-1:0] dat_q;

  assign req_ready  = !vld_q || resp_ready;
  assign accept     = req_valid && req_ready;
  assign resp_valid = vld_q;
  assign resp_rdata = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      dat_q <= req_write ? '0 : rd_word;
    end else if (resp_ready) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/otp_cfg_regs.sv
module otp_cfg_regs
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PTR_W     = 2,
  parameter int LAST_WORD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output ctrl_t             ctrl,
  output logic              autoinc,
  output logic [PTR_W-1:0]  word_ptr,
  output logic              sel_ctrl,
  output logic              sel_data,
  output logic              sel_ptr
);
  ctrl_t            ctrl_q;
  logic             ainc_q;
  logic [PTR_W-1:0] ptr_q;
  logic             data_rd;

  assign sel_ctrl = (int'(req_addr) == OFS_CTRL);
  assign sel_data = (int'(req_addr) == OFS_DATA);
  assign sel_ptr  = (int'(req_addr) == OFS_PTR);
  assign data_rd  = accept && !req_write && sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      ainc_q <= 1'b0;
    end else if (accept && req_write) begin
      if (sel_ctrl) ctrl_q <= ctrl_unpack(req_wdata);
      if (sel_ptr)  ainc_q <= req_wdata[B_AINC];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ctrl_q.ptr_clr) begin
      ptr_q <= '0;
    end else if (data_rd && ainc_q && (int'(ptr_q) != LAST_WORD)) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ctrl     = ctrl_q;
  assign autoinc  = ainc_q;
  assign word_ptr = ptr_q;
endmodule

// File: rtl/otp_strobe_gate.sv
module otp_strobe_gate #(
  parameter int MIN_CYC = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic pwr_on,
  input  logic par_mode,
  output logic latch_en,
  output logic word_valid
);
  localparam int CNT_W = $clog2(MIN_CYC + 1);

  logic             strb_d;
  logic             armed_q;
  logic [CNT_W-1:0] low_cnt;
  logic             rise;
  logic             fall;
  logic             vld_q;

  assign rise = strobe && !strb_d;
  assign fall = !strobe && strb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_d  <= 1'b0;
      armed_q <= 1'b0;
      low_cnt <= '0;
    end else begin
      strb_d <= strobe;
      if (fall) begin
        armed_q <= 1'b1;
        low_cnt <= CNT_W'(1);
      end else if (rise) begin
        armed_q <= 1'b0;
      end else if (armed_q && !strobe && (int'(low_cnt) < MIN_CYC)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign latch_en = rise && armed_q && (int'(low_cnt) >= MIN_CYC) && pwr_on && par_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vld_q <= 1'b0;
    else if (!pwr_on)  vld_q <= 1'b0;
    else if (latch_en) vld_q <= 1'b1;
  end

  assign word_valid = vld_q;
endmodule

// File: rtl/otp_fuse_words.sv
module otp_fuse_words
  import otp_pkg::*;
#(
  parameter int                   FUSE_BITS  = 69,
  parameter logic [FUSE_BITS-1:0] FUSE_VALUE = '1,
  parameter int                   NUM_WORDS  = 3,
  parameter int                   PTR_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [PTR_W-1:0]  word_ptr,
  output logic [WORD_W-1:0] word
);
  localparam int                PADW   = NUM_WORDS * WORD_W;
  localparam logic [PADW-1:0]   PADDED = PADW'(FUSE_VALUE);

  logic [WORD_W-1:0] shadow [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shadow[k] <= '0;
      else if (latch_en) shadow[k] <= PADDED[k*WORD_W +: WORD_W];
    end
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < NUM_WORDS; k++) begin
      if (int'(word_ptr) == k) word = shadow[k];
    end
  end
endmodule

// File: rtl/otp_par_read_port.sv
module otp_par_read_port
  import otp_pkg::*;
#(
  parameter int                   ADDR_W         = 8,
  parameter int                   FUSE_BITS      = 69,
  parameter logic [FUSE_BITS-1:0] FUSE_VALUE     = '1,
  parameter int                   STROBE_MIN_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [31:0]       resp_rdata
);
  localparam int NUM_WORDS = (FUSE_BITS + WORD_W - 1) / WORD_W;
  localparam int PTR_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int LAST_WORD = NUM_WORDS - 1;

  logic              accept;
  ctrl_t             ctrl;
  logic              autoinc_w;
  logic [PTR_W-1:0]  word_ptr_w;
  logic              sel_ctrl, sel_data, sel_ptr;
  logic              latch_en;
  logic              word_valid_w;
  logic [WORD_W-1:0] fuse_word;
  logic [WORD_W-1:0] ptr_view;
  logic [WORD_W-1:0] rd_word;
  logic              pwr_on_w, par_mode_w, ptr_clr_w;

  assign pwr_on_w   = ctrl.pwr_on;
  assign par_mode_w = !ctrl.serial;
  assign ptr_clr_w  = ctrl.ptr_clr;

  otp_rsp_stage u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .rd_word(rd_word),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata)
  );

  otp_cfg_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .LAST_WORD(LAST_WORD)) u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .ctrl(ctrl),
    .autoinc(autoinc_w), .word_ptr(word_ptr_w),
    .sel_ctrl(sel_ctrl), .sel_data(sel_data), .sel_ptr(sel_ptr)
  );

  otp_strobe_gate #(.MIN_CYC(STROBE_MIN_CYC)) u_strb (
    .clk(clk), .rst_n(rst_n), .strobe(ctrl.strobe), .pwr_on(pwr_on_w),
    .par_mode(par_mode_w), .latch_en(latch_en), .word_valid(word_valid_w)
  );

  otp_fuse_words #(.FUSE_BITS(FUSE_BITS), .FUSE_VALUE(FUSE_VALUE),
                   .NUM_WORDS(NUM_WORDS), .PTR_W(PTR_W)) u_words (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en),
    .word_ptr(word_ptr_w), .word(fuse_word)
  );

  always_comb begin
    ptr_view = '0;
    ptr_view[PTR_W-1:0] = word_ptr_w;
    ptr_view[B_AINC]    = autoinc_w;
  end

  always_comb begin
    rd_word = '0;
    if (sel_ctrl)     rd_word = ctrl_pack(ctrl);
    else if (sel_ptr) rd_word = ptr_view;
    else if (sel_data && pwr_on_w && par_mode_w && word_valid_w) rd_word = fuse_word;
  end
endmodule

// File: rtl/otp_par_read_chk.sv
module otp_par_read_chk #(
  parameter int ADDR_W    = 8,
  parameter int PTR_W     = 2,
  parameter int LAST_WORD = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [31:0]       resp_rdata,
  input logic              pwr_on,
  input logic              par_mode,
  input logic              word_valid,
  input logic              autoinc,
  input logic              ptr_clr,
  input logic [PTR_W-1:0]  word_ptr
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R11
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_rdata));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready);

  // R11
  resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> resp_valid);

  // R11
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !(resp_valid && !resp_ready) |=> !resp_valid);

  // R3
  data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !req_write && (int'(req_addr) == 'h04) && !(pwr_on && par_mode && word_valid)
    |=> resp_rdata == 32'h0);

  // R8
  ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(word_ptr) <= LAST_WORD);

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !autoinc && !ptr_clr |=> $stable(word_ptr));

  // R7
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> word_ptr == '0);

  // R10
  pwr_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |=> !word_valid);
endmodule

bind otp_par_read_port otp_par_read_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .LAST_WORD(LAST_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .resp_valid(resp_valid),
  .resp_ready(resp_ready), .resp_rdata(resp_rdata), .pwr_on(pwr_on_w),
  .par_mode(par_mode_w), .word_valid(word_valid_w), .autoinc(autoinc_w),
  .ptr_clr(ptr_clr_w), .word_ptr(word_ptr_w)
);

// File: tb/sim_otp_par_read_port.sv
`timescale 1ns/1ps
module sim_otp_par_read_port;
  localparam int                FB   = 97;
  localparam logic [FB-1:0]     FVAL = {1'b1, 32'h89AB_CDEF, 32'h0123_4567, 32'hDEAD_BEEF};
  localparam int                MINC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [31:0] resp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  otp_par_read_port #(.ADDR_W(8), .FUSE_BITS(FB), .FUSE_VALUE(FVAL),
                      .STROBE_MIN_CYC(MINC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [7:0]  gap;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0000_8000, 8'd0, 8'd1},   // R1 control reset value
    '{1'b0, 8'h08, 32'h0, 32'h0000_0000, 8'd0, 8'd1},   // R1 pointer reset value
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd0, 8'd1},   // R1 data reset value
    '{1'b1, 8'h00, 32'h0000_0000, 32'h0, 8'd0, 8'd2},   // R2 parallel mode
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 8'd0, 8'd2},   // R2 readback
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd0, 8'd3},   // R3 power off
    '{1'b1, 8'h00, 32'h0000_2000, 32'h0, 8'd0, 8'd3},   // power on
    '{1'b1, 8'h08, 32'h0000_0100, 32'h0, 8'd0, 8'd8},   // R8 auto-increment on
    '{1'b1, 8'h00, 32'h0000_6000, 32'h0, 8'd0, 8'd7},   // R7 pointer clear set
    '{1'b1, 8'h00, 32'h0000_2000, 32'h0, 8'd0, 8'd7},   // R7 pointer clear release
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd0, 8'd4},   // R4 strobe high
    '{1'b1, 8'h00, 32'h0000_2000, 32'h0, 8'd0, 8'd4},   // R4 strobe low
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd12, 8'd4},  // R4 strobe high after long low
    '{1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF, 8'd0, 8'd6},   // R6 word 0
    '{1'b0, 8'h08, 32'h0, 32'h0000_0101, 8'd0, 8'd8},   // R8 pointer advanced
    '{1'b0, 8'h04, 32'h0, 32'h0123_4567, 8'd0, 8'd6},   // R6 word 1
    '{1'b0, 8'h04, 32'h0, 32'h89AB_CDEF, 8'd0, 8'd6},   // R6 word 2
    '{1'b0, 8'h04, 32'h0, 32'h0000_0001, 8'd0, 8'd6},   // R6 last word zero-padded
    '{1'b0, 8'h04, 32'h0, 32'h0000_0001, 8'd0, 8'd8},   // R8 saturated at last
    '{1'b0, 8'h08, 32'h0, 32'h0000_0103, 8'd0, 8'd8},   // R8 pointer at last
    '{1'b1, 8'h08, 32'h0000_0000, 32'h0, 8'd0, 8'd9},   // R9 auto-increment off
    '{1'b1, 8'h00, 32'h0000_6008, 32'h0, 8'd0, 8'd7},   // R7 clear set
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd0, 8'd7},   // R7 clear release
    '{1'b0, 8'h08, 32'h0, 32'h0000_0000, 8'd0, 8'd7},   // R7 pointer back at 0
    '{1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF, 8'd0, 8'd9},   // R9 read
    '{1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF, 8'd0, 8'd9},   // R9 same word again
    '{1'b0, 8'h08, 32'h0, 32'h0000_0000, 8'd0, 8'd9},   // R9 pointer unchanged
    '{1'b1, 8'h00, 32'h0000_A008, 32'h0, 8'd0, 8'd3},   // R3 serial mode
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd0, 8'd3},   // R3 gated in serial mode
    '{1'b1, 8'h00, 32'h0000_20F8, 32'h0, 8'd0, 8'd2},   // R2 noise bits written
    '{1'b0, 8'h00, 32'h0, 32'h0000_2008, 8'd0, 8'd2},   // R2 only defined bits kept
    '{1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF, 8'd0, 8'd3},   // R3 back in parallel mode
    '{1'b0, 8'h0C, 32'h0, 32'h0000_0000, 8'd0, 8'd12},  // R12 unmapped read
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0, 8'd0, 8'd12},  // R12 unmapped write
    '{1'b0, 8'h00, 32'h0, 32'h0000_2008, 8'd0, 8'd12},  // R12 control untouched
    '{1'b1, 8'h00, 32'h0000_0008, 32'h0, 8'd0, 8'd10},  // R10 power off
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd0, 8'd10},  // R10 power on again
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd0, 8'd10},  // R10 data invalid
    '{1'b1, 8'h00, 32'h0000_2000, 32'h0, 8'd0, 8'd5},   // R5 strobe low
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd0, 8'd5},   // R5 strobe high too soon
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 8'd0, 8'd5},   // R5 still invalid
    '{1'b1, 8'h00, 32'h0000_2000, 32'h0, 8'd0, 8'd4},   // R4 strobe low
    '{1'b1, 8'h00, 32'h0000_2008, 32'h0, 8'd12, 8'd4},  // R4 long low, rise
    '{1'b0, 8'h04, 32'h0, 32'hDEAD_BEEF, 8'd0, 8'd4}    // R4 valid again
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // R11: one response per request on the next edge
  task automatic xact(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input int req, output logic [31:0] rd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!resp_valid) begin
      n_chk++; n_bad++;
      $display("FAIL R11 (req R%0d): actual resp_valid 0 expected 1", req);
    end
    rd = resp_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [31:0] held;
    do_reset();
    check(1, {31'b0, resp_valid}, 32'h0);  // R1 no response after reset

    for (int i = 0; i < NV; i++) begin
      repeat (int'(VEC[i].gap)) @(negedge clk);
      xact(VEC[i].wr, VEC[i].addr, VEC[i].wdata, int'(VEC[i].req), rd);
      check(int'(VEC[i].req), rd, VEC[i].exp);
    end

    // R11 back-pressure: response held, request side stalled
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h00;
    @(negedge clk);
    req_valid = 1'b0;
    held = resp_rdata;
    check(11, {31'b0, resp_valid}, 32'h1);
    check(11, held, 32'h0000_2008);
    req_valid = 1'b1; req_addr = 8'h08;
    repeat (3) begin
      @(negedge clk);
      check(11, {31'b0, req_ready}, 32'h0);
      check(11, resp_rdata, held);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(11, resp_rdata, 32'h0000_0000);  // queued pointer read completes
    @(negedge clk);
    check(11, {31'b0, resp_valid}, 32'h0);

    // R1 reset mid-run clears all state
    do_reset();
    xact(1'b0, 8'h00, 32'h0, 1, rd); check(1, rd, 32'h0000_8000);
    xact(1'b0, 8'h04, 32'h0, 1, rd); check(1, rd, 32'h0);

    // R4 a rise with no earlier fall does not latch
    xact(1'b1, 8'h00, 32'h0000_2000, 4, rd);
    repeat (12) @(negedge clk);
    xact(1'b1, 8'h00, 32'h0000_2008, 4, rd);
    xact(1'b0, 8'h04, 32'h0, 4, rd); check(4, rd, 32'h0);

    // R4 strobe sequence run while in serial mode does not latch
    xact(1'b1, 8'h00, 32'h0000_A000, 4, rd);
    repeat (12) @(negedge clk);
    xact(1'b1, 8'h00, 32'h0000_A008, 4, rd);
    xact(1'b1, 8'h00, 32'h0000_2008, 4, rd);
    xact(1'b0, 8'h04, 32'h0, 4, rd); check(4, rd, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule